// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the host bus of a page-programmed flash array and its page write sequencer. It watches completed bus write cycles for fixed unlock sequences of address/data pairs. From them it keeps the software write protection flag, the product identification mode and the lock bits of the two 8 KB boot blocks. It grants or refuses each write as a page-load write, and it pulses a chip-erase start. It also feeds the read multiplexer with identification and lock-detect bytes.

Every sequence opens with two key writes: address bits [14:0] = 5555 with data AA, then 2AAA with data 55. A third write at 5555 carries an operation byte. Operation 80 extends the sequence by a second key pair and a sixth operation byte. Lock setting takes a seventh write that selects the block. The page sequencer reports the end of a page load on `page_done`, and this closes the window that a three-write arm sequence opened. Any write that breaks a sequence returns the decoder to idle. Cycles without a write leave the progress of a sequence untouched.

Top module: `flcmd_decoder`

## Requirements
- R1: After reset `prot_on` is 1, `id_mode` is 0, `boot_lock` is 00, `erase_go` is 0 and `load_grant` is 0.
- R2: While `prot_on` is 1 and no load window is open, no write is granted (`load_grant` stays 0 in the cycle of the write).
- R3: The three writes 5555/AA, 2AAA/55, 5555/A0 set `prot_on` to 1 and open a load window from the next cycle. Every following write is granted without decoding until a `page_done` pulse closes the window.
- R4: The six writes 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/20 clear `prot_on`. While `prot_on` is 0, writes that do not advance a sequence are granted, and writes that advance one are not.
- R5: A write with a wrong address or wrong data at any step returns the decoder to idle, so the writes that follow do not finish the broken sequence.
- R6: Clock cycles with `wr_valid` low in the middle of a sequence do not disturb it.
- R7: The extended sequence with sixth byte 60 sets `id_mode` to 1. In that mode, `id_data` is DA for `rd_addr` 00000 and 45 for `rd_addr` 00001.
- R8: In `id_mode`, `id_data` at `rd_addr` 00002 shows the lower block lock and at 3FFF2 the upper block lock: FF when locked, FE when unlocked.
- R9: The three writes 5555/AA, 2AAA/55, 5555/F0 clear `id_mode`.
- R10: The extended sequence with sixth byte 40, followed by a seventh write at 5555 with data 00 (lower) or FF (upper), sets `boot_lock[0]` (lower block, address bits [17:13] all 0) or `boot_lock[1]` (upper block, bits [17:13] all 1). Lock bits are never cleared.
- R11: A write whose address falls in a locked block is never granted, even inside an open load window.
- R12: The extended sequence with sixth byte 10 raises `erase_go` for exactly one cycle after the sixth write, but only when `boot_lock` is 00.
- R13: `id_data` is 00 whenever `id_mode` is 0, and at any `rd_addr` other than the four identification addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe for a completed bus write |
| wr_addr | input | 18 | Address of the completed write |
| wr_data | input | 8 | Data of the completed write |
| page_done | input | 1 | Page sequencer reports that the page load has ended |
| rd_addr | input | 18 | Current read address |
| load_grant | output | 1 | The write in this cycle is accepted as page-load data |
| erase_go | output | 1 | One-cycle chip-erase start |
| id_mode | output | 1 | Read mux selects `id_data` instead of the array |
| prot_on | output | 1 | Software write protection is active |
| boot_lock | output | 2 | Lock bits: [0] lower block, [1] upper block |
| id_data | output | 8 | Identification or lock-detect byte for `rd_addr` |

## Verification
The hardest states to reach are the deep ones: a lock readback, or a locked block hit inside an open load window. Each needs a run of up to seven exact writes, with protection first turned off and then back on. The stimulus builds these runs from small sequence tasks. It locks the lower block while unprotected, then reads the lock bytes in identification mode. It locks the upper block after that, and finally re-arms protection. This leaves a load window open over a locked address. Broken sequences are driven both at the second key write and inside the extended half, and idle cycles are inserted between key writes.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
   // progress through an unlock sequence
   typedef enum logic [2:0] {
      ST_IDLE, ST_K1, ST_K2, ST_X3, ST_X4, ST_X5, ST_B6
   } step_t;

   // decoded command, valid for one write
   typedef enum logic [2:0] {
      CMD_NONE, CMD_ARM, CMD_ID_EXIT, CMD_PROT_OFF,
      CMD_ID_ENTER, CMD_ERASE, CMD_LOCK_LO, CMD_LOCK_HI
   } cmd_t;

   localparam int KEY_W = 15;
   localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
   localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
   localparam logic [7:0] KEY_DATA_A = 8'hAA;
   localparam logic [7:0] KEY_DATA_B = 8'h55;
   localparam logic [7:0] OP_ARM     = 8'hA0;
   localparam logic [7:0] OP_ID_EXIT = 8'hF0;
   localparam logic [7:0] OP_EXTEND  = 8'h80;
   localparam logic [7:0] OP_PROT_OFF = 8'h20;
   localparam logic [7:0] OP_ID_ENTER = 8'h60;
   localparam logic [7:0] OP_ERASE   = 8'h10;
   localparam logic [7:0] OP_LOCK    = 8'h40;
   localparam logic [7:0] SEL_LOWER  = 8'h00;
   localparam logic [7:0] SEL_UPPER  = 8'hFF;
endpackage

// File: rtl/flcmd_seq.sv
module flcmd_seq
   import flcmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             bypass,
   input  logic [KEY_W-1:0] key_addr,
   input  logic [7:0]       key_data,
   output cmd_t             cmd,
   output logic             consumed
);
   step_t state, nxt;
   cmd_t  dec;
   logic  hit, at_a, at_b, active;

   assign at_a   = (key_addr == KEY_ADDR_A);
   assign at_b   = (key_addr == KEY_ADDR_B);
   assign active = wr_valid && !bypass;

   always_comb begin
      nxt = ST_IDLE;
      dec = CMD_NONE;
      hit = 1'b0;
      case (state)
         ST_IDLE, ST_X3: begin
            if (at_a && key_data == KEY_DATA_A) begin
               nxt = (state == ST_IDLE) ? ST_K1 : ST_X4;
               hit = 1'b1;
            end
         end
         ST_K1, ST_X4: begin
            if (at_b && key_data == KEY_DATA_B) begin
               nxt = (state == ST_K1) ? ST_K2 : ST_X5;
               hit = 1'b1;
            end
         end
         ST_K2: begin
            if (at_a) begin
               hit = 1'b1;
               case (key_data)
                  OP_ARM:     dec = CMD_ARM;
                  OP_ID_EXIT: dec = CMD_ID_EXIT;
                  OP_EXTEND:  nxt = ST_X3;
                  default:    hit = 1'b0;
               endcase
            end
         end
         ST_X5: begin
            if (at_a) begin
               hit = 1'b1;
               case (key_data)
                  OP_PROT_OFF: dec = CMD_PROT_OFF;
                  OP_ID_ENTER: dec = CMD_ID_ENTER;
                  OP_ERASE:    dec = CMD_ERASE;
                  OP_LOCK:     nxt = ST_B6;
                  default:     hit = 1'b0;
               endcase
            end
         end
         ST_B6: begin
            if (at_a && key_data == SEL_LOWER) begin
               dec = CMD_LOCK_LO;
               hit = 1'b1;
            end else if (at_a && key_data == SEL_UPPER) begin
               dec = CMD_LOCK_HI;
               hit = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign consumed = active && hit;
   assign cmd      = active ? dec : CMD_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state <= ST_IDLE;
      else if (active) state <= nxt;
   end

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> $stable(state));
   // R5
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !bypass && !consumed) |=> (state == ST_IDLE));
endmodule

// File: rtl/flcmd_mode.sv
module flcmd_mode
   import flcmd_pkg::*;
#(
   parameter bit PROT_INIT = 1'b1,
   parameter int N_BLK     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_t             cmd,
   input  logic             page_done,
   output logic             prot_on,
   output logic             armed,
   output logic             id_mode,
   output logic [N_BLK-1:0] boot_lock,
   output logic             erase_go
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_on   <= PROT_INIT;
         armed     <= 1'b0;
         id_mode   <= 1'b0;
         boot_lock <= '0;
         erase_go  <= 1'b0;
      end else begin
         erase_go <= (cmd == CMD_ERASE) && (boot_lock == '0);
         if (page_done) armed <= 1'b0;
         case (cmd)
            CMD_ARM: begin
               prot_on <= 1'b1;
               armed   <= 1'b1;
            end
            CMD_PROT_OFF: prot_on      <= 1'b0;
            CMD_ID_ENTER: id_mode      <= 1'b1;
            CMD_ID_EXIT:  id_mode      <= 1'b0;
            CMD_LOCK_LO:  boot_lock[0] <= 1'b1;
            CMD_LOCK_HI:  boot_lock[N_BLK-1] <= 1'b1;
            default: ;
         endcase
      end
   end

   // R4
   prot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_on) |-> ($past(cmd) == CMD_PROT_OFF));
   // R3
   arm_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> prot_on);
   // R10
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((boot_lock & $past(boot_lock)) == $past(boot_lock)));
   // R12
   erase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> ($past(boot_lock) == '0));
   // R12
   erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);
endmodule

// File: rtl/flcmd_idrd.sv
module flcmd_idrd #(
   parameter int          ADDR_W = 18,
   parameter logic [7:0]  MFR_ID = 8'hDA,
   parameter logic [7:0]  DEV_ID = 8'h45
) (
   input  logic              id_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        boot_lock,
   output logic [7:0]        id_data
);
   localparam logic [ADDR_W-1:0] PROBE_MFR = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] PROBE_DEV = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] PROBE_LO  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] PROBE_HI  = ~ADDR_W'(13);

   function automatic logic [7:0] lock_byte(input logic locked);
      return {7'h7F, locked};
   endfunction

   always_comb begin
      id_data = 8'h00;
      if (id_mode) begin
         if (rd_addr == PROBE_MFR)      id_data = MFR_ID;
         else if (rd_addr == PROBE_DEV) id_data = DEV_ID;
         else if (rd_addr == PROBE_LO)  id_data = lock_byte(boot_lock[0]);
         else if (rd_addr == PROBE_HI)  id_data = lock_byte(boot_lock[1]);
      end
   end
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
   import flcmd_pkg::*;
#(
   parameter int          ADDR_W    = 18,
   parameter int          BOOT_W    = 13,
   parameter bit          PROT_INIT = 1'b1,
   parameter logic [7:0]  MFR_ID    = 8'hDA,
   parameter logic [7:0]  DEV_ID    = 8'h45
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              page_done,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              load_grant,
   output logic              erase_go,
   output logic              id_mode,
   output logic              prot_on,
   output logic [1:0]        boot_lock,
   output logic [7:0]        id_data
);
   localparam int N_BLK = 2;
   localparam int TAG_W = ADDR_W - BOOT_W;

   if (ADDR_W < KEY_W + 1 || TAG_W < 2) begin : g_bad_cfg
      $error("flcmd_decoder: address too narrow for keys or boot blocks");
   end

   cmd_t             cmd;
   logic             consumed, armed;
   logic [N_BLK-1:0] blk_hit;

   flcmd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .bypass   (armed),
      .key_addr (wr_addr[KEY_W-1:0]),
      .key_data (wr_data),
      .cmd      (cmd),
      .consumed (consumed)
   );

   flcmd_mode #(.PROT_INIT(PROT_INIT), .N_BLK(N_BLK)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .page_done (page_done),
      .prot_on   (prot_on),
      .armed     (armed),
      .id_mode   (id_mode),
      .boot_lock (boot_lock),
      .erase_go  (erase_go)
   );

   flcmd_idrd #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_idrd (
      .id_mode   (id_mode),
      .rd_addr   (rd_addr),
      .boot_lock (boot_lock),
      .id_data   (id_data)
   );

   for (genvar b = 0; b < N_BLK; b++) begin : g_blk
      localparam logic [TAG_W-1:0] TAG = (b == 0) ? '0 : '1;
      assign blk_hit[b] = boot_lock[b] && (wr_addr[ADDR_W-1:BOOT_W] == TAG);
   end

   assign load_grant = wr_valid && !consumed && (armed || !prot_on) && (blk_hit == '0);

   // R2
   grant_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_grant |-> (wr_valid && (armed || !prot_on)));
   // R11
   lower_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_lock[0] && wr_addr[ADDR_W-1:BOOT_W] == '0) |-> !load_grant);
   // R13
   id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !id_mode |-> (id_data == 8'h00));
   // R7
   id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_mode && rd_addr == '0) |-> (id_data == MFR_ID));
endmodule

// File: tb/test_flcmd_decoder.sv
`timescale 1ns/100ps
module test_flcmd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [17:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        page_done = 1'b0;
   logic [17:0] rd_addr = '0;
   logic        load_grant, erase_go, id_mode, prot_on;
   logic [1:0]  boot_lock;
   logic [7:0]  id_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   flcmd_decoder i_flcmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .page_done(page_done), .rd_addr(rd_addr),
      .load_grant(load_grant), .erase_go(erase_go), .id_mode(id_mode),
      .prot_on(prot_on), .boot_lock(boot_lock), .id_data(id_data)
   );

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: one completed write, expected grant pushed to scoreboard
   task automatic wr(input logic [17:0] a, input logic [7:0] d, input bit g, input string req);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      exp_q.push_back(g); tag_q.push_back(req);
      @(posedge clk); #1 wr_valid = 1'b0;
   endtask

   // monitor: compares load_grant against the scoreboard
   initial forever begin
      @(negedge clk); #2;
      if (wr_valid) begin
         if (exp_q.size() == 0) cmp("scoreboard", 8'(load_grant), 8'hXX);
         else cmp(tag_q.pop_front(), 8'(load_grant), 8'(exp_q.pop_front()));
      end
   end

   task automatic keys(input string req);
      wr(18'h05555, 8'hAA, 1'b0, req);
      wr(18'h02AAA, 8'h55, 1'b0, req);
   endtask

   task automatic ext(input logic [7:0] op, input string req);
      keys(req);
      wr(18'h05555, 8'h80, 1'b0, req);
      keys(req);
      wr(18'h05555, op, 1'b0, req);
   endtask

   task automatic chk(input string req, input logic [7:0] act_sel, input logic [7:0] exp);
      @(negedge clk); #1;
      case (act_sel)
         8'd0: cmp(req, 8'(prot_on), exp);
         8'd1: cmp(req, 8'(id_mode), exp);
         8'd2: cmp(req, 8'(boot_lock), exp);
         8'd3: cmp(req, 8'(erase_go), exp);
         default: cmp(req, 8'(load_grant), exp);
      endcase
   endtask

   task automatic rd(input logic [17:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); rd_addr = a; #1;
      cmp(req, id_data, exp);
   endtask

   task automatic pdone();
      @(negedge clk); page_done = 1'b1;
      @(posedge clk); #1 page_done = 1'b0;
   endtask

   initial begin
      #20000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 prot", 0, 8'h01);
      chk("R1 id", 1, 8'h00);
      chk("R1 lock", 2, 8'h00);
      chk("R1 erase", 3, 8'h00);
      chk("R1 grant", 4, 8'h00);
      rd(18'h00000, 8'h00, "R13 id off");
      // R2 protected, plain write refused
      wr(18'h08000, 8'h11, 1'b0, "R2");
      // R3 arm then load window
      keys("R3"); wr(18'h05555, 8'hA0, 1'b0, "R3");
      wr(18'h08000, 8'h12, 1'b1, "R3 load");
      wr(18'h05555, 8'hAA, 1'b1, "R3 no decode");
      chk("R3 prot", 0, 8'h01);
      pdone();
      wr(18'h08001, 8'h14, 1'b0, "R3 window closed");
      // R5 broken at second key
      wr(18'h05555, 8'hAA, 1'b0, "R5");
      wr(18'h02AAA, 8'h54, 1'b0, "R5");
      wr(18'h05555, 8'hA0, 1'b0, "R5");
      wr(18'h08000, 8'h15, 1'b0, "R5 not armed");
      // R6 idle cycles inside a sequence
      wr(18'h05555, 8'hAA, 1'b0, "R6");
      repeat (5) @(negedge clk);
      wr(18'h02AAA, 8'h55, 1'b0, "R6");
      repeat (3) @(negedge clk);
      wr(18'h05555, 8'hA0, 1'b0, "R6");
      wr(18'h08000, 8'h16, 1'b1, "R6 armed");
      pdone();
      // R4 disable protection
      ext(8'h20, "R4");
      chk("R4 prot off", 0, 8'h00);
      wr(18'h08000, 8'h17, 1'b1, "R4 plain");
      wr(18'h02000, 8'h18, 1'b1, "R4 plain2");
      chk("R4 still off", 0, 8'h00);
      // R12 erase with no lock
      ext(8'h10, "R12");
      chk("R12 pulse", 3, 8'h01);
      chk("R12 one cycle", 3, 8'h00);
      // R10 lock lower
      ext(8'h40, "R10"); wr(18'h05555, 8'h00, 1'b0, "R10");
      chk("R10 lower", 2, 8'h01);
      wr(18'h00100, 8'h19, 1'b0, "R11 lower locked");
      wr(18'h3FF00, 8'h1A, 1'b1, "R11 upper free");
      // R12 erase refused once locked
      ext(8'h10, "R12");
      chk("R12 refused", 3, 8'h00);
      // R7 ID mode
      ext(8'h60, "R7");
      chk("R7 id", 1, 8'h01);
      rd(18'h00000, 8'hDA, "R7 mfr");
      rd(18'h00001, 8'h45, "R7 dev");
      rd(18'h00002, 8'hFF, "R8 lower locked");
      rd(18'h3FFF2, 8'hFE, "R8 upper free");
      rd(18'h00003, 8'h00, "R13 other addr");
      // R10 lock upper
      ext(8'h40, "R10"); wr(18'h05555, 8'hFF, 1'b0, "R10");
      chk("R10 both", 2, 8'h03);
      rd(18'h3FFF2, 8'hFF, "R8 upper locked");
      // R9 exit ID mode
      keys("R9"); wr(18'h05555, 8'hF0, 1'b0, "R9");
      chk("R9 id off", 1, 8'h00);
      rd(18'h00000, 8'h00, "R13 after exit");
      // R3 and R11: re-arm, locked block inside window
      keys("R3"); wr(18'h05555, 8'hA0, 1'b0, "R3");
      chk("R3 prot on", 0, 8'h01);
      wr(18'h3FF00, 8'h1B, 1'b0, "R11 upper in window");
      wr(18'h00010, 8'h1C, 1'b0, "R11 lower in window");
      wr(18'h10000, 8'h1D, 1'b1, "R3 window");
      pdone();
      // R5 broken inside extended half: protection stays on
      keys("R5"); wr(18'h05555, 8'h80, 1'b0, "R5");
      wr(18'h05555, 8'hAA, 1'b0, "R5");
      wr(18'h02AAA, 8'h54, 1'b0, "R5");
      wr(18'h05555, 8'h20, 1'b0, "R5");
      chk("R5 prot kept", 0, 8'h01);
      repeat (2) @(negedge clk);
      report();
   end
endmodule